// File: doc/BRIEF.md
# Control-Bit Configurable Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit with no opcode. Each of the two operands passes through its own conditioning path. That path can clear the operand to zero and then invert it bit by bit. The two conditioned operands drive both an adder and a bitwise AND. A select bit picks one of those two results, and a final stage can invert it. Two flags describe the final value: one is set when the value is zero, the other is set when it is negative.

Setting the six control bits together yields constants, pass-through of either operand, negation, increment, decrement, subtraction in either direction, AND and OR, all without a decoder. The block has no clock and no state, so it can sit anywhere in a datapath. Its outputs depend only on its present inputs.

Top module: `cfg_alu`

## Requirements
- R1: When `clr_a` is 1 the A path carries zero ahead of its inversion stage; when 0 it carries `opnd_a` unchanged.
- R2: When `inv_a` is 1 the A path is inverted bit by bit after the clear stage; when 0 it passes unchanged.
- R3: `clr_b` and `inv_b` act on the B path exactly as `clr_a` and `inv_a` act on the A path, and in the same order.
- R4: When `sel_sum` is 1 the selected value is the sum of the conditioned operands modulo 2^WIDTH, with the carry out of the top bit dropped. When it is 0 the selected value is their bitwise AND.
- R5: When `inv_res` is 1 `result` is the bitwise inverse of the selected value; when 0 it equals the selected value.
- R6: `is_zero` is 1 exactly when every bit of `result` is 0.
- R7: `is_neg` equals bit WIDTH-1 of `result`, so a zero result always gives `is_neg` = 0.
- R8: With all six control bits at 1, `result` is 1 for any operands.
- R9: With `clr_a`, `inv_a`, `clr_b` and `sel_sum` at 1 and `inv_b` and `inv_res` at 0, `result` has every bit set (the value -1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| clr_a | input | 1 | Force the A path to zero |
| inv_a | input | 1 | Invert the A path after clearing |
| clr_b | input | 1 | Force the B path to zero |
| inv_b | input | 1 | Invert the B path after clearing |
| sel_sum | input | 1 | 1 selects the sum, 0 selects the AND |
| inv_res | input | 1 | Invert the selected value |
| result | output | WIDTH | Final value |
| is_zero | output | 1 | Result is all zeros |
| is_neg | output | 1 | Result sign bit |

## Verification
The block holds no state, so a fault in any stage shows at `result` or the flags in the same cycle the inputs are applied, and the bench samples one half period later. A swapped clear and invert order shows only when both bits of a path are set. A dropped or kept carry shows only on sums that wrap. The sweep therefore runs all 64 control settings against corner operands (0, 1, -1, the largest positive value and the most negative value) and against random operands. A flag tied to the wrong bit or to the wrong reduction shows on the zero and sign-boundary operands.

// File: rtl/cfg_alu_pkg.sv
package cfg_alu_pkg;
  typedef struct packed {
    logic clr;
    logic inv;
  } path_ctl_t;
endpackage

// File: rtl/cfg_alu_cond.sv
module cfg_alu_cond
  import cfg_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] din,
  input  path_ctl_t        ctl,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] cleared;

  always_comb begin
    cleared = ctl.clr ? '0 : din;
    dout    = ctl.inv ? ~cleared : cleared;
  end

  // R1 for path A, R3 for path B: a cleared path yields zero or all ones
  always_comb begin
    if (ctl.clr && !ctl.inv)
      p_clear_path_r1: assert (dout == '0);
    if (ctl.clr && ctl.inv)
      p_clear_inv_path_r2: assert (&dout);
  end
endmodule

// File: rtl/cfg_alu_core.sv
module cfg_alu_core #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sel_sum,
  input  logic             inv_res,
  output logic [WIDTH-1:0] res
);
  logic [WIDTH-1:0] sum_v;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] pick;

  always_comb begin
    sum_v = a + b;
    and_v = a & b;
    pick  = sel_sum ? sum_v : and_v;
    res   = inv_res ? ~pick : pick;
  end

  // R4: the AND result can never set a bit that is clear in either input
  always_comb begin
    if (!sel_sum && !inv_res)
      p_and_subset_r4: assert (((res & ~a) | (res & ~b)) == '0);
  end
endmodule

// File: rtl/cfg_alu_flags.sv
module cfg_alu_flags #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] value,
  output logic             zero,
  output logic             neg
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    zero = ~|value;
    neg  = value[MSB];
  end

  // R6/R7: a zero value is never negative
  always_comb begin
    p_flag_excl_r7: assert (!(zero && neg));
  end
endmodule

// File: rtl/cfg_alu.sv
module cfg_alu
  import cfg_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             clr_a,
  input  logic             inv_a,
  input  logic             clr_b,
  input  logic             inv_b,
  input  logic             sel_sum,
  input  logic             inv_res,
  output logic [WIDTH-1:0] result,
  output logic             is_zero,
  output logic             is_neg
);
  localparam int NPATH = 2;

  path_ctl_t        ctl   [NPATH];
  logic [WIDTH-1:0] raw   [NPATH];
  logic [WIDTH-1:0] cond  [NPATH];

  assign ctl[0] = '{clr: clr_a, inv: inv_a};
  assign ctl[1] = '{clr: clr_b, inv: inv_b};
  assign raw[0] = opnd_a;
  assign raw[1] = opnd_b;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    cfg_alu_cond #(.WIDTH(WIDTH)) i_cond (
      .din  (raw[p]),
      .ctl  (ctl[p]),
      .dout (cond[p])
    );
  end

  cfg_alu_core #(.WIDTH(WIDTH)) i_core (
    .a       (cond[0]),
    .b       (cond[1]),
    .sel_sum (sel_sum),
    .inv_res (inv_res),
    .res     (result)
  );

  cfg_alu_flags #(.WIDTH(WIDTH)) i_flags (
    .value (result),
    .zero  (is_zero),
    .neg   (is_neg)
  );

  always_comb begin
    if (clr_a && inv_a && clr_b && inv_b && sel_sum && inv_res)
      p_const_one_r8: assert (result == WIDTH'(1));
    if (clr_a && inv_a && clr_b && !inv_b && sel_sum && !inv_res)
      p_minus_one_r9: assert (&result);
    p_zero_flag_r6: assert (is_zero == (result == '0));
  end
endmodule

// File: tb/test_cfg_alu.sv
module test_cfg_alu;
  localparam int W = 16;
  localparam int PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [W-1:0] a, b, res;
  logic ca, ia, cb, ib, ss, ir, zf, nf;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  cfg_alu #(.WIDTH(W)) i_cfg_alu (
    .opnd_a(a), .opnd_b(b), .clr_a(ca), .inv_a(ia), .clr_b(cb), .inv_b(ib),
    .sel_sum(ss), .inv_res(ir), .result(res), .is_zero(zf), .is_neg(nf)
  );

  // control vector packing: {clr_a, inv_a, clr_b, inv_b, sel_sum, inv_res}
  task automatic apply(input logic [5:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    {ca, ia, cb, ib, ss, ir} = c;
    a = x;
    b = y;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (ctl %b a %h b %h)",
               tag, act, exp, {ca, ia, cb, ib, ss, ir}, a, b);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [5:0] c, input logic [W-1:0] x,
                                         input logic [W-1:0] y);
    logic [W-1:0] px, py, v;
    px = c[5] ? '0 : x;
    if (c[4]) px = ~px;
    py = c[3] ? '0 : y;
    if (c[2]) py = ~py;
    v = c[1] ? W'(px + py) : (px & py);
    if (c[0]) v = ~v;
    return v;
  endfunction

  task automatic full(input logic [5:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] e;
    apply(c, x, y);
    e = model(c, x, y);
    chk("R1 R2 R3 R4 R5 result", res, e);
    chk("R6 zero flag", W'(zf), W'(e == '0));
    chk("R7 sign flag", W'(nf), W'(e[W-1]));
  endtask

  initial begin
    logic [W-1:0] corner [5];
    corner = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000};
    {ca, ia, cb, ib, ss, ir} = '0;
    a = '0;
    b = '0;
    // idle state: all inputs low gives 0 AND 0 = 0
    @(negedge clk);
    chk("R4 idle result", res, '0);
    chk("R6 idle zero", W'(zf), W'(1));
    chk("R7 idle sign", W'(nf), W'(0));
    // targeted cases
    apply(6'b100010, 16'hBEEF, 16'h1234);
    chk("R1 clear A passes B", res, 16'h1234);
    apply(6'b010000, 16'h00F0, 16'hFFFF);
    chk("R2 invert A", res, 16'hFF0F);
    apply(6'b101110, 16'h5555, 16'h0F0F);
    chk("R3 invert B after clear", res, 16'hFFFF);
    apply(6'b000010, 16'hFFFF, 16'h0001);
    chk("R4 sum wraps", res, 16'h0000);
    chk("R6 wrapped sum is zero", W'(zf), W'(1));
    apply(6'b000001, 16'hF0F0, 16'hFF00);
    chk("R5 inverted AND", res, 16'h0FFF);
    apply(6'b000010, 16'h7FFF, 16'h0001);
    chk("R7 sign at boundary", W'(nf), W'(1));
    apply(6'b111111, 16'h1357, 16'h9BDF);
    chk("R8 constant one", res, 16'h0001);
    apply(6'b111010, 16'h2468, 16'hACE0);
    chk("R9 minus one", res, 16'hFFFF);
    // sweep all control settings
    for (int c = 0; c < 64; c++) begin
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          full(6'(c), corner[i], corner[j]);
      for (int r = 0; r < 40; r++)
        full(6'(c), W'($urandom), W'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule